// File: doc/BRIEF.md
# DMA Controller Control-Port Write Decoder

This block takes every byte written to the single control port of a DMA controller and turns the stream into programmed register state. A byte written while nothing is pending is a base byte. It is classified by bit pattern into one of seven register groups, numbered 0 to 6. The flag bits of a base byte in groups 0 to 4 can queue a number of parameter bytes that follow it. Each later write is stored in the register at the head of that queue, in a fixed order, until the queue is empty again.

Group 6 bytes are one-byte commands. They enable or disable the engine, set or clear interrupt enable, reset the command state, load or continue a transfer, or ask for a read-mask byte. Commands that act on the status, counters or read-back path are not executed here. They leave the block as one-cycle pulses. All outputs are registered and take their new value on the clock edge that accepts the write. The transfer engine itself is outside this block.

Top module: `dma_ctrl_decoder`

## Requirements
- R1: The grouping of a base byte with bit 7 clear is as follows. If either of bits 1:0 is set, the byte is group 0. Otherwise it is group 1 when bit 2 is set and group 2 when bit 2 is clear.
- R2: A base byte with bit 7 set is tested against these rules in the order given, and the first match wins. Bits 1:0 = 00 gives group 3. Bits 1:0 = 01 with bits 7:5 not equal to 111 gives group 4. Bits 2:0 = 010 with bit 6 clear gives group 5; bit 3 of a group 5 byte drives `ready_pol`. Every other byte with bit 7 set is group 6. A group 6 byte that is not a listed command changes nothing except `dma_enable`.
- R3: A group 0 byte loads `cmd_type` from bits 1:0. Its bits 3, 4, 5 and 6 queue, in that order, these follow-on bytes: port A address low, port A address high, block length low and block length high.
- R4: A group 1 byte with bit 6 set queues one byte that goes to `timing_a`. A group 2 byte with bit 6 set queues one byte that goes to `timing_b`. Neither byte changes any other output.
- R5: A group 3 byte has these effects: bit 3 queues the mask byte, bit 4 queues the match byte (mask first), bit 5 is loaded into `int_enable`, and bit 6 is loaded into `dma_enable`.
- R6: A group 4 byte has these effects: bits 6:5 load `xfer_mode`, and bits 2, 3 and 4 queue, in that order, port B address low, port B address high and the interrupt control byte.
- R7: When the interrupt control byte is written, two more bytes may be added to the tail of the queue. If bit 3 of that byte is set, a pulse byte is appended. If bit 4 is set, a vector byte is appended after it.
- R8: Some group 6 command codes change registers directly. 0x87 sets `dma_enable` and 0x83 leaves it clear. 0xAB sets `int_enable` and 0xAF clears it. 0x8B pulses `clr_flags_p`. 0xC3 clears `cmd_type`, `dma_enable` and `int_enable`.
- R9: Other group 6 command codes produce a one-cycle pulse. 0xA7 pulses `read_seq_p`, 0xB3 pulses `force_rdy_p` and 0xBF pulses `read_stat_p`. 0xBB queues one read-mask byte; writing that byte loads `read_mask` and pulses `rmask_wr_p`.
- R10: Command 0xCF pulses `load_p` and `clr_flags_p` and leaves `dma_enable` clear. Command 0xD3 pulses `cont_p` and `clr_flags_p` and sets `dma_enable`.
- R11: Every accepted write clears `dma_enable`. Only a group 3 byte with bit 6 set, command 0x87 or command 0xD3 leaves it set after that write. A follow-on byte always leaves it clear.
- R12: While the queue holds entries, each write goes to the head register, is not decoded as a base byte, and shortens the queue by one. With `wr_en` low, no output changes and every pulse is low. Outputs change on the edge that accepts the write.
- R13: After reset all registers, the queue and all pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control-port write strobe, one byte per cycle |
| wr_data | input | 8 | Byte written to the control port |
| cmd_type | output | 2 | Command type from group 0 |
| dma_enable | output | 1 | Engine enable |
| int_enable | output | 1 | Interrupt enable |
| xfer_mode | output | 2 | Transfer mode from group 4 |
| ready_pol | output | 1 | Ready polarity from group 5 |
| port_a_addr | output | 16 | Port A start address |
| port_b_addr | output | 16 | Port B start address |
| block_len | output | 16 | Block length |
| mask_byte | output | 8 | Match mask byte |
| match_byte | output | 8 | Match value byte |
| int_ctrl | output | 8 | Interrupt control byte |
| int_pulse | output | 8 | Interrupt pulse byte |
| int_vector | output | 8 | Interrupt vector byte |
| read_mask | output | 8 | Read-back mask |
| timing_a | output | 8 | Port A timing byte |
| timing_b | output | 8 | Port B timing byte |
| clr_flags_p | output | 1 | Pulse: clear match and end-of-block flags |
| load_p | output | 1 | Pulse: load counters from addresses |
| cont_p | output | 1 | Pulse: continue transfer |
| read_seq_p | output | 1 | Pulse: start read-back sequence |
| force_rdy_p | output | 1 | Pulse: force ready |
| read_stat_p | output | 1 | Pulse: read status |
| rmask_wr_p | output | 1 | Pulse: read mask written |

## Verification
The bench goes after the classification boundaries, using bytes that sit next to each rule. 0xE1 looks like group 4 but has bits 7:5 = 111, and 0xCA looks like group 5 but has bit 6 set. A decoder that checked the rules in the wrong order would change `xfer_mode` or `ready_pol` on these bytes. The longest queue chain is group 4 followed by an interrupt control byte with both extension bits set. A queue that appended at the wrong place, or dropped the tail, would put the pulse or vector byte in the wrong register, or would decode it as a new base byte. Follow-on bytes that look like commands, and writes after an enabling write, check that `dma_enable` is cleared by every write and that command codes inside the queue are stored, not executed.

// File: rtl/dmad_pkg.sv
package dmad_pkg;

    typedef enum logic [2:0] {
        GRP0, GRP1, GRP2, GRP3, GRP4, GRP5, GRP6
    } grp_e;

    // Register addressed by a queued follow-on byte
    typedef enum logic [3:0] {
        T_NONE   = 4'd0,
        T_A_LO   = 4'd1,
        T_A_HI   = 4'd2,
        T_LEN_LO = 4'd3,
        T_LEN_HI = 4'd4,
        T_TIM_A  = 4'd5,
        T_TIM_B  = 4'd6,
        T_MASK   = 4'd7,
        T_MATCH  = 4'd8,
        T_B_LO   = 4'd9,
        T_B_HI   = 4'd10,
        T_INTC   = 4'd11,
        T_PULSE  = 4'd12,
        T_VECT   = 4'd13,
        T_RMASK  = 4'd14
    } tgt_e;

    typedef struct packed {
        logic dis;
        logic ena;
        logic clr_flags;
        logic int_on;
        logic int_off;
        logic want_rmask;
        logic soft_rst;
        logic load;
        logic cont;
        logic read_seq;
        logic force_rdy;
        logic read_stat;
    } cmd6_t;

    typedef struct packed {
        logic [1:0]  cmd;
        logic        en;
        logic        ie;
        logic [1:0]  mode;
        logic        rpol;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] len;
        logic [7:0]  mask;
        logic [7:0]  match;
        logic [7:0]  intc;
        logic [7:0]  pls;
        logic [7:0]  vec;
        logic [7:0]  rmask;
        logic [7:0]  ta;
        logic [7:0]  tb;
        logic        p_clr;
        logic        p_load;
        logic        p_cont;
        logic        p_rseq;
        logic        p_frdy;
        logic        p_rstat;
        logic        p_rmw;
    } regs_t;

endpackage

// File: rtl/dmad_classify.sv
module dmad_classify
    import dmad_pkg::*;
(
    input  logic [7:0] byte_in,
    output grp_e       grp
);
    always_comb begin
        if (!byte_in[7]) begin
            if (byte_in[1:0] != 2'b00)      grp = GRP0;
            else if (byte_in[2])            grp = GRP1;
            else                            grp = GRP2;
        end else begin
            if (byte_in[1:0] == 2'b00)
                grp = GRP3;
            else if (byte_in[1:0] == 2'b01 && byte_in[7:5] != 3'b111)
                grp = GRP4;
            else if (byte_in[2:0] == 3'b010 && !byte_in[6])
                grp = GRP5;
            else
                grp = GRP6;
        end
    end
endmodule

// File: rtl/dmad_cmd6.sv
module dmad_cmd6
    import dmad_pkg::*;
(
    input  logic [7:0] code,
    output cmd6_t      act
);
    always_comb begin
        act = '0;
        case (code)
            8'h83: act.dis        = 1'b1;
            8'h87: act.ena        = 1'b1;
            8'h8B: act.clr_flags  = 1'b1;
            8'hA7: act.read_seq   = 1'b1;
            8'hAB: act.int_on     = 1'b1;
            8'hAF: act.int_off    = 1'b1;
            8'hB3: act.force_rdy  = 1'b1;
            8'hBB: act.want_rmask = 1'b1;
            8'hBF: act.read_stat  = 1'b1;
            8'hC3: act.soft_rst   = 1'b1;
            8'hCF: act.load       = 1'b1;
            8'hD3: act.cont       = 1'b1;
            default: act = '0;
        endcase
    end
endmodule

// File: rtl/dmad_queue.sv
module dmad_queue
    import dmad_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int NCAND = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  tgt_e             cand [NCAND],
    input  logic [NCAND-1:0] cand_en,
    output tgt_e             head,
    output logic [CW-1:0]    cnt
);
    typedef struct packed {
        tgt_e [DEPTH-1:0] ent;
        logic [CW-1:0]    cnt;
    } qst_t;

    qst_t q_d, q_q;
    logic [CW-1:0] fill;

    always_comb begin
        q_d  = q_q;
        fill = q_q.cnt;
        if (pop && q_q.cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                q_d.ent[i] = q_q.ent[i+1];
            end
            q_d.ent[DEPTH-1] = T_NONE;
            fill = q_q.cnt - 1'b1;
        end
        // append enabled candidates at the tail, in candidate order
        for (int i = 0; i < NCAND; i++) begin
            if (cand_en[i] && fill < CW'(DEPTH)) begin
                q_d.ent[IW'(fill)] = cand[i];
                fill = fill + 1'b1;
            end
        end
        q_d.cnt = fill;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head = q_q.ent[0];
    assign cnt  = q_q.cnt;
endmodule

// File: rtl/dma_ctrl_decoder.sv
module dma_ctrl_decoder
    import dmad_pkg::*;
#(
    parameter int QDEPTH = 6,
    localparam int NCAND = 4,
    localparam int CW    = $clog2(QDEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [1:0]  cmd_type,
    output logic        dma_enable,
    output logic        int_enable,
    output logic [1:0]  xfer_mode,
    output logic        ready_pol,
    output logic [15:0] port_a_addr,
    output logic [15:0] port_b_addr,
    output logic [15:0] block_len,
    output logic [7:0]  mask_byte,
    output logic [7:0]  match_byte,
    output logic [7:0]  int_ctrl,
    output logic [7:0]  int_pulse,
    output logic [7:0]  int_vector,
    output logic [7:0]  read_mask,
    output logic [7:0]  timing_a,
    output logic [7:0]  timing_b,
    output logic        clr_flags_p,
    output logic        load_p,
    output logic        cont_p,
    output logic        read_seq_p,
    output logic        force_rdy_p,
    output logic        read_stat_p,
    output logic        rmask_wr_p
);
    regs_t            st_d, st_q;
    grp_e             grp;
    cmd6_t            c6;
    tgt_e             q_head;
    logic [CW-1:0]    q_cnt;
    logic             pop;
    tgt_e             cand [NCAND];
    logic [NCAND-1:0] cand_en;

    dmad_classify u_cls (.byte_in(wr_data), .grp(grp));
    dmad_cmd6     u_c6  (.code(wr_data), .act(c6));

    dmad_queue #(.DEPTH(QDEPTH), .NCAND(NCAND)) u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .pop     (pop),
        .cand    (cand),
        .cand_en (cand_en),
        .head    (q_head),
        .cnt     (q_cnt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.p_clr   = 1'b0;
        st_d.p_load  = 1'b0;
        st_d.p_cont  = 1'b0;
        st_d.p_rseq  = 1'b0;
        st_d.p_frdy  = 1'b0;
        st_d.p_rstat = 1'b0;
        st_d.p_rmw   = 1'b0;
        pop          = 1'b0;
        cand_en      = '0;
        for (int i = 0; i < NCAND; i++) cand[i] = T_NONE;

        if (wr_en) begin
            st_d.en = 1'b0;
            if (q_cnt != '0) begin
                // follow-on parameter byte
                pop = 1'b1;
                case (q_head)
                    T_A_LO:   st_d.a[7:0]    = wr_data;
                    T_A_HI:   st_d.a[15:8]   = wr_data;
                    T_LEN_LO: st_d.len[7:0]  = wr_data;
                    T_LEN_HI: st_d.len[15:8] = wr_data;
                    T_TIM_A:  st_d.ta        = wr_data;
                    T_TIM_B:  st_d.tb        = wr_data;
                    T_MASK:   st_d.mask      = wr_data;
                    T_MATCH:  st_d.match     = wr_data;
                    T_B_LO:   st_d.b[7:0]    = wr_data;
                    T_B_HI:   st_d.b[15:8]   = wr_data;
                    T_INTC: begin
                        st_d.intc  = wr_data;
                        cand[0]    = T_PULSE;
                        cand[1]    = T_VECT;
                        cand_en[0] = wr_data[3];
                        cand_en[1] = wr_data[4];
                    end
                    T_PULSE:  st_d.pls       = wr_data;
                    T_VECT:   st_d.vec       = wr_data;
                    T_RMASK: begin
                        st_d.rmask = wr_data;
                        st_d.p_rmw = 1'b1;
                    end
                    default: ;
                endcase
            end else begin
                case (grp)
                    GRP0: begin
                        st_d.cmd = wr_data[1:0];
                        cand[0]  = T_A_LO;
                        cand[1]  = T_A_HI;
                        cand[2]  = T_LEN_LO;
                        cand[3]  = T_LEN_HI;
                        cand_en  = wr_data[6:3];
                    end
                    GRP1: begin
                        cand[0]    = T_TIM_A;
                        cand_en[0] = wr_data[6];
                    end
                    GRP2: begin
                        cand[0]    = T_TIM_B;
                        cand_en[0] = wr_data[6];
                    end
                    GRP3: begin
                        cand[0]    = T_MASK;
                        cand[1]    = T_MATCH;
                        cand_en[0] = wr_data[3];
                        cand_en[1] = wr_data[4];
                        st_d.ie    = wr_data[5];
                        st_d.en    = wr_data[6];
                    end
                    GRP4: begin
                        st_d.mode  = wr_data[6:5];
                        cand[0]    = T_B_LO;
                        cand[1]    = T_B_HI;
                        cand[2]    = T_INTC;
                        cand_en[0] = wr_data[2];
                        cand_en[1] = wr_data[3];
                        cand_en[2] = wr_data[4];
                    end
                    GRP5: st_d.rpol = wr_data[3];
                    default: begin
                        if (c6.ena)       st_d.en = 1'b1;
                        if (c6.int_on)    st_d.ie = 1'b1;
                        if (c6.int_off)   st_d.ie = 1'b0;
                        if (c6.clr_flags) st_d.p_clr = 1'b1;
                        if (c6.read_seq)  st_d.p_rseq = 1'b1;
                        if (c6.force_rdy) st_d.p_frdy = 1'b1;
                        if (c6.read_stat) st_d.p_rstat = 1'b1;
                        if (c6.want_rmask) begin
                            cand[0]    = T_RMASK;
                            cand_en[0] = 1'b1;
                        end
                        if (c6.soft_rst) begin
                            st_d.cmd = 2'b00;
                            st_d.ie  = 1'b0;
                        end
                        if (c6.load) begin
                            st_d.p_load = 1'b1;
                            st_d.p_clr  = 1'b1;
                        end
                        if (c6.cont) begin
                            st_d.p_cont = 1'b1;
                            st_d.p_clr  = 1'b1;
                            st_d.en     = 1'b1;
                        end
                        // c6.dis: enable already cleared by the write
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_type    = st_q.cmd;
    assign dma_enable  = st_q.en;
    assign int_enable  = st_q.ie;
    assign xfer_mode   = st_q.mode;
    assign ready_pol   = st_q.rpol;
    assign port_a_addr = st_q.a;
    assign port_b_addr = st_q.b;
    assign block_len   = st_q.len;
    assign mask_byte   = st_q.mask;
    assign match_byte  = st_q.match;
    assign int_ctrl    = st_q.intc;
    assign int_pulse   = st_q.pls;
    assign int_vector  = st_q.vec;
    assign read_mask   = st_q.rmask;
    assign timing_a    = st_q.ta;
    assign timing_b    = st_q.tb;
    assign clr_flags_p = st_q.p_clr;
    assign load_p      = st_q.p_load;
    assign cont_p      = st_q.p_cont;
    assign read_seq_p  = st_q.p_rseq;
    assign force_rdy_p = st_q.p_frdy;
    assign read_stat_p = st_q.p_rstat;
    assign rmask_wr_p  = st_q.p_rmw;
endmodule

// File: rtl/dmad_chk.sv
module dmad_chk
    import dmad_pkg::*;
#(
    parameter int QDEPTH = 6,
    localparam int CW = $clog2(QDEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [7:0]    wr_data,
    input logic [CW-1:0] q_cnt,
    input tgt_e          q_head,
    input logic          dma_enable,
    input logic [15:0]   port_a_addr,
    input logic [15:0]   port_b_addr,
    input logic [15:0]   block_len,
    input logic          clr_flags_p,
    input logic          load_p,
    input logic          cont_p,
    input logic          read_seq_p,
    input logic          force_rdy_p,
    input logic          read_stat_p,
    input logic          rmask_wr_p
);
    a_r11_follow_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && q_cnt != '0 |=> !dma_enable);

    a_r12_qcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt <= CW'(QDEPTH));

    a_r12_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && q_cnt != '0 && q_head != T_INTC |=> q_cnt == $past(q_cnt) - 1'b1);

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(port_a_addr) && $stable(port_b_addr) && $stable(block_len)
                   && !clr_flags_p && !load_p && !cont_p && !rmask_wr_p);

    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && q_cnt == '0 && wr_data == 8'hCF |=> load_p && clr_flags_p && !dma_enable);

    a_r10_cont: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && q_cnt == '0 && wr_data == 8'hD3 |=> cont_p && clr_flags_p && dma_enable);

    a_r9_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_p, cont_p, read_seq_p, force_rdy_p, read_stat_p, rmask_wr_p}));
endmodule

bind dma_ctrl_decoder dmad_chk #(.QDEPTH(QDEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .q_cnt       (q_cnt),
    .q_head      (q_head),
    .dma_enable  (dma_enable),
    .port_a_addr (port_a_addr),
    .port_b_addr (port_b_addr),
    .block_len   (block_len),
    .clr_flags_p (clr_flags_p),
    .load_p      (load_p),
    .cont_p      (cont_p),
    .read_seq_p  (read_seq_p),
    .force_rdy_p (force_rdy_p),
    .read_stat_p (read_stat_p),
    .rmask_wr_p  (rmask_wr_p)
);

// File: tb/dma_ctrl_decoder_tb_top.sv
module dma_ctrl_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cmd_type, xfer_mode;
    logic dma_enable, int_enable, ready_pol;
    logic [15:0] port_a_addr, port_b_addr, block_len;
    logic [7:0] mask_byte, match_byte, int_ctrl, int_pulse, int_vector, read_mask, timing_a, timing_b;
    logic clr_flags_p, load_p, cont_p, read_seq_p, force_rdy_p, read_stat_p, rmask_wr_p;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_ctrl_decoder dut_i (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [1:0] e_cmd, e_mode;
    logic e_en, e_ie, e_rp;
    logic [15:0] e_a, e_b, e_len;
    logic [7:0] e_mask, e_match, e_intc, e_pls, e_vec, e_rmask, e_ta, e_tb;
    logic e_clr, e_load, e_cont, e_rseq, e_frdy, e_rstat, e_rmw;
    int mq [16];
    int mcnt;

    // follow-on target codes (bench-local)
    localparam int K_ALO=1, K_AHI=2, K_LLO=3, K_LHI=4, K_TA=5, K_TB=6, K_MSK=7,
                   K_MAT=8, K_BLO=9, K_BHI=10, K_IC=11, K_PL=12, K_VC=13, K_RM=14;

    function automatic int group_of(logic [7:0] v);
        if (!v[7]) return (v[1:0] != 0) ? 0 : (v[2] ? 1 : 2);
        if (v[1:0] == 2'b00) return 3;
        if (v[1:0] == 2'b01 && v[7:5] != 3'b111) return 4;
        if (v[2:0] == 3'b010 && !v[6]) return 5;
        return 6;
    endfunction

    task automatic push(int k);
        mq[mcnt] = k;
        mcnt++;
    endtask

    task automatic model_reset();
        e_cmd = 0; e_mode = 0; e_en = 0; e_ie = 0; e_rp = 0;
        e_a = 0; e_b = 0; e_len = 0;
        e_mask = 0; e_match = 0; e_intc = 0; e_pls = 0; e_vec = 0; e_rmask = 0; e_ta = 0; e_tb = 0;
        mcnt = 0;
    endtask

    task automatic clear_pulses();
        {e_clr, e_load, e_cont, e_rseq, e_frdy, e_rstat, e_rmw} = '0;
    endtask

    task automatic model_write(logic [7:0] v);
        clear_pulses();
        e_en = 0;
        if (mcnt > 0) begin
            int k = mq[0];
            for (int i = 0; i < 15; i++) mq[i] = mq[i+1];
            mcnt--;
            case (k)
                K_ALO: e_a[7:0] = v;
                K_AHI: e_a[15:8] = v;
                K_LLO: e_len[7:0] = v;
                K_LHI: e_len[15:8] = v;
                K_TA:  e_ta = v;
                K_TB:  e_tb = v;
                K_MSK: e_mask = v;
                K_MAT: e_match = v;
                K_BLO: e_b[7:0] = v;
                K_BHI: e_b[15:8] = v;
                K_IC: begin
                    e_intc = v;
                    if (v[3]) push(K_PL);
                    if (v[4]) push(K_VC);
                end
                K_PL:  e_pls = v;
                K_VC:  e_vec = v;
                K_RM: begin e_rmask = v; e_rmw = 1; end
                default: ;
            endcase
        end else begin
            case (group_of(v))
                0: begin
                    e_cmd = v[1:0];
                    if (v[3]) push(K_ALO);
                    if (v[4]) push(K_AHI);
                    if (v[5]) push(K_LLO);
                    if (v[6]) push(K_LHI);
                end
                1: if (v[6]) push(K_TA);
                2: if (v[6]) push(K_TB);
                3: begin
                    if (v[3]) push(K_MSK);
                    if (v[4]) push(K_MAT);
                    e_ie = v[5];
                    e_en = v[6];
                end
                4: begin
                    e_mode = v[6:5];
                    if (v[2]) push(K_BLO);
                    if (v[3]) push(K_BHI);
                    if (v[4]) push(K_IC);
                end
                5: e_rp = v[3];
                default: begin
                    case (v)
                        8'h87: e_en = 1;
                        8'hAB: e_ie = 1;
                        8'hAF: e_ie = 0;
                        8'h8B: e_clr = 1;
                        8'hA7: e_rseq = 1;
                        8'hB3: e_frdy = 1;
                        8'hBF: e_rstat = 1;
                        8'hBB: push(K_RM);
                        8'hC3: begin e_cmd = 0; e_ie = 0; end
                        8'hCF: begin e_load = 1; e_clr = 1; end
                        8'hD3: begin e_cont = 1; e_clr = 1; e_en = 1; end
                        default: ;
                    endcase
                end
            endcase
        end
    endtask

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk("R3",  {tag, " cmd_type"},    16'(cmd_type),    16'(e_cmd));
        chk("R3",  {tag, " port_a_addr"}, port_a_addr,      e_a);
        chk("R3",  {tag, " block_len"},   block_len,        e_len);
        chk("R4",  {tag, " timing_a"},    16'(timing_a),    16'(e_ta));
        chk("R4",  {tag, " timing_b"},    16'(timing_b),    16'(e_tb));
        chk("R5",  {tag, " mask_byte"},   16'(mask_byte),   16'(e_mask));
        chk("R5",  {tag, " match_byte"},  16'(match_byte),  16'(e_match));
        chk("R6",  {tag, " xfer_mode"},   16'(xfer_mode),   16'(e_mode));
        chk("R6",  {tag, " port_b_addr"}, port_b_addr,      e_b);
        chk("R6",  {tag, " int_ctrl"},    16'(int_ctrl),    16'(e_intc));
        chk("R7",  {tag, " int_pulse"},   16'(int_pulse),   16'(e_pls));
        chk("R7",  {tag, " int_vector"},  16'(int_vector),  16'(e_vec));
        chk("R2",  {tag, " ready_pol"},   16'(ready_pol),   16'(e_rp));
        chk("R8",  {tag, " int_enable"},  16'(int_enable),  16'(e_ie));
        chk("R11", {tag, " dma_enable"},  16'(dma_enable),  16'(e_en));
        chk("R8",  {tag, " clr_flags_p"}, 16'(clr_flags_p), 16'(e_clr));
        chk("R9",  {tag, " read_mask"},   16'(read_mask),   16'(e_rmask));
        chk("R9",  {tag, " pulses"},
            16'({read_seq_p, force_rdy_p, read_stat_p, rmask_wr_p}),
            16'({e_rseq, e_frdy, e_rstat, e_rmw}));
        chk("R10", {tag, " load/cont"},   16'({load_p, cont_p}), 16'({e_load, e_cont}));
    endtask

    task automatic wr(logic [7:0] v, string tag);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(posedge clk);
        #1;
        model_write(v);
        compare_all(tag);
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = $urandom;
        @(posedge clk);
        #1;
        clear_pulses();
        compare_all({tag, " R12 idle"});
    endtask

    logic [7:0] cmds [12] = '{8'h83, 8'h87, 8'h8B, 8'hA7, 8'hAB, 8'hAF,
                              8'hB3, 8'hBB, 8'hBF, 8'hC3, 8'hCF, 8'hD3};

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0D3A));
        model_reset();
        clear_pulses();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare_all("R13 reset");

        // R1/R3: group 0 with all four follow-on bytes
        wr(8'h79, "R1 g0 base");
        wr(8'h11, "R3 a_lo"); wr(8'h22, "R3 a_hi");
        wr(8'h33, "R3 len_lo"); wr(8'h44, "R3 len_hi");
        chk("R3", "addr_a final", port_a_addr, 16'h2211);
        // R4: timing bytes, command-like values are stored not executed
        wr(8'h44, "R1 g1 base"); wr(8'h87, "R4 timing_a");
        chk("R11", "cmd-like follow-on leaves enable clear", 16'(dma_enable), 16'h0);
        wr(8'h40, "R1 g2 base"); wr(8'hCF, "R4 timing_b");
        chk("R10", "follow-on 0xCF no load", 16'(load_p), 16'h0);
        // R5/R11
        wr(8'hF8, "R5 g3 base");
        chk("R5", "g3 sets enable", 16'(dma_enable), 16'h1);
        wr(8'h0F, "R5 mask"); wr(8'hF0, "R5 match");
        // R6/R7 longest chain
        wr(8'hBD, "R6 g4 base");
        wr(8'h34, "R6 b_lo"); wr(8'h12, "R6 b_hi");
        wr(8'h18, "R7 intc"); wr(8'h55, "R7 pulse"); wr(8'h66, "R7 vector");
        chk("R7", "vector final", 16'(int_vector), 16'h0066);
        // R2 boundaries
        wr(8'hE1, "R2 e1 falls to g6");
        chk("R2", "0xE1 keeps mode", 16'(xfer_mode), 16'h1);
        wr(8'h8A, "R2 g5 rpol=1");
        wr(8'hCA, "R2 ca falls to g6");
        chk("R2", "0xCA keeps ready_pol", 16'(ready_pol), 16'h1);
        wr(8'h82, "R2 g5 rpol=0");
        // R8-R10 commands
        foreach (cmds[i]) begin
            wr(cmds[i], "R8 cmd");
            if (cmds[i] == 8'hBB) wr(8'h7E, "R9 read mask");
        end

        // random stream
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] v;
            if (mcnt == 0 && ($urandom % 3) == 0) v = cmds[$urandom % 12];
            else v = 8'($urandom);
            wr(v, "R12 rnd");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule